// File: doc/BRIEF.md
# Auto-Baud Single-Wire Key State Reporter

This block is the slave side of a tiny serial link that reports ten key states to a host. The host sends one fixed request character, an upper-case 'P' (0x50), framed as 8N1 with the LSB first. It arrives on the shared single wire, or on a separate receive pin when two-wire mode is selected. The block has no programmed baud rate. It times the low run at the start of the character to find the bit period. It checks the rest of the character at that rate. A short turnaround follows. The block then drives a two-byte bitmap of the keys back on the single wire at the same rate and releases the wire once the last stop bit has been driven.

An active-low change flag tells the host that some key has been pressed or released since the last report, so the host only needs to poll when the flag is low. The flag clears during the turnaround, before the reply starts.

The controller is one state machine with these states. IDLE waits for a falling edge. MEASURE counts the low run; it goes to SAMPLE when the period is valid and to HUNT when it is too long or out of range. SAMPLE checks data bits 4 to 7 and the stop bit at mid-bit. It goes to TURN when they match, to HUNT on a low stop bit, and to IDLE on any other mismatch. TURN waits out the turnaround and clears the flag, then goes to SEND. SEND shifts out the 20-bit reply and returns to IDLE. HUNT waits for the line to go high, then goes to IDLE.

Top module: `keyrep_onewire`

## Requirements
- R1: A request is accepted only when its five-bit low run (start bit plus data bits 0 to 3 of 0x50, LSB first) gives a bit period, equal to the low-run length divided by 5, that lies within MIN_BIT to MAX_BIT clock cycles.
- R2: The reply's start bit begins between 1 and 3 measured bit periods after the start of the request's stop bit, and every reply bit lasts one measured period.
- R3: The reply is two 8N1 characters, LSB first, each with a low start bit and a high stop bit. The first is 0x40 with bits 5:0 set by keys 5:0. The second is 0x40 with bits 3:0 set by keys 9:6. With keys 0, 2 and 7 pressed, the reply is 0x45 then 0x42.
- R4: line_oe is high only while the reply is being sent. It falls one full bit period after the second stop bit began, while that stop bit is high.
- R5: A character whose bits differ from 0x50 but which passes the low-run measurement gets no reply.
- R6: A request whose stop bit is low gets no reply, and a valid request sent afterwards is answered.
- R7: A request whose bit period is outside MIN_BIT to MAX_BIT cycles gets no reply.
- R8: change_n goes low within two cycles of any change on keys and stays low until a valid request is answered. It is high when the reply begins.
- R9: With two_wire high, requests are taken only from rx_in. With two_wire low, requests are taken only from line_in. The reply is always driven on line_oe/line_do.
- R10: After reset, change_n is high and line_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Level sensed on the shared single wire |
| rx_in | input | 1 | Separate request input used in two-wire mode |
| two_wire | input | 1 | 1 selects rx_in as the request source |
| keys | input | NKEYS | Current key states, 1 = pressed |
| line_oe | output | 1 | Drive enable for the single wire |
| line_do | output | 1 | Data driven on the single wire when enabled |
| change_n | output | 1 | Low when key states changed since last report |

## Verification
The assertions assume that the host releases the single wire whenever line_oe is high. They also assume that keys do not change in the two cycles before a reply starts, since a fresh change there rightly sets the flag again. The bench models the wire as the block's drive when enabled and the host's level otherwise. It keeps keys fixed from before each request until the reply has ended, and it changes two_wire only while the line is idle.

// File: rtl/keyrep_pkg.sv
package keyrep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_SAMPLE,
        ST_TURN,
        ST_SEND,
        ST_HUNT
    } kr_state_e;

    // expected levels for data bits 4..7 then stop bit (index 0 = bit 4)
    localparam logic [4:0] TAIL_PATTERN = 5'b10101;
    localparam int         TAIL_BITS    = 5;
    localparam int         FRAME_BITS   = 20;
endpackage

// File: rtl/keyrep_sync.sv
module keyrep_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            q      <= '1;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/keyrep_frame.sv
module keyrep_frame #(
    parameter int NKEYS = 10
) (
    input  logic [NKEYS-1:0]                  keys,
    output logic [keyrep_pkg::FRAME_BITS-1:0] frame
);
    localparam int LO_KEYS = 6;
    localparam int HI_KEYS = NKEYS - LO_KEYS;

    logic [7:0] byte_lo, byte_hi;

    always_comb begin
        byte_lo = 8'h40;
        byte_hi = 8'h40;
        for (int i = 0; i < LO_KEYS; i++) byte_lo[i] = keys[i];
        for (int i = 0; i < HI_KEYS; i++) byte_hi[i] = keys[LO_KEYS + i];
        // transmitted from bit 0 upward: start, data LSB first, stop
        frame = {1'b1, byte_hi, 1'b0, 1'b1, byte_lo, 1'b0};
    end
endmodule

// File: rtl/keyrep_change.sv
module keyrep_change #(
    parameter int NKEYS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NKEYS-1:0] keys,
    input  logic             clr,
    output logic             change_n
);
    logic [NKEYS-1:0] prev_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= keys;
            if (keys != prev_q) flag_q <= 1'b1;
            else if (clr)       flag_q <= 1'b0;
        end
    end

    assign change_n = ~flag_q;
endmodule

// File: rtl/keyrep_onewire.sv
module keyrep_onewire
    import keyrep_pkg::*;
#(
    parameter int MIN_BIT = 26,
    parameter int MAX_BIT = 125,
    parameter int NKEYS   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             rx_in,
    input  logic             two_wire,
    input  logic [NKEYS-1:0] keys,
    output logic             line_oe,
    output logic             line_do,
    output logic             change_n
);
    localparam int CNT_W     = $clog2(5 * MAX_BIT + 8);
    localparam int LOW_LIMIT = 5 * MAX_BIT + 4;

    kr_state_e             state_q, state_d;
    logic [1:0]            sync_q;
    logic                  sel_s;
    logic [CNT_W-1:0]      low_q, bit_q, tmr_q, meas;
    logic [4:0]            idx_q;
    logic                  bad_q, bad_next, tick, meas_ok;
    logic [FRAME_BITS-1:0] frame_q, frame_w;

    keyrep_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rx_in, line_in}),
        .q    (sync_q)
    );

    keyrep_frame #(.NKEYS(NKEYS)) u_frame (
        .keys (keys),
        .frame(frame_w)
    );

    keyrep_change #(.NKEYS(NKEYS)) u_change (
        .clk     (clk),
        .rst_n   (rst_n),
        .keys    (keys),
        .clr     (state_q == ST_TURN),
        .change_n(change_n)
    );

    assign sel_s    = two_wire ? sync_q[1] : sync_q[0];
    assign tick     = (tmr_q == '0);
    assign meas     = low_q / CNT_W'(5);
    assign meas_ok  = (meas >= CNT_W'(MIN_BIT)) && (meas <= CNT_W'(MAX_BIT));
    assign bad_next = bad_q | (sel_s != TAIL_PATTERN[idx_q[2:0]]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!sel_s) state_d = ST_MEASURE;
            ST_MEASURE: begin
                if (sel_s)                              state_d = meas_ok ? ST_SAMPLE : ST_HUNT;
                else if (low_q >= CNT_W'(LOW_LIMIT))    state_d = ST_HUNT;
            end
            ST_SAMPLE: begin
                if (tick && idx_q == 5'(TAIL_BITS - 1)) begin
                    if (!bad_next)   state_d = ST_TURN;
                    else if (!sel_s) state_d = ST_HUNT;
                    else             state_d = ST_IDLE;
                end
            end
            ST_TURN:    if (tick) state_d = ST_SEND;
            ST_SEND:    if (tick && idx_q == 5'(FRAME_BITS - 1)) state_d = ST_IDLE;
            ST_HUNT:    if (sel_s) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath: low-run counter, bit timer, sample index, reply shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q   <= '0;
            bit_q   <= CNT_W'(MIN_BIT);
            tmr_q   <= '0;
            idx_q   <= '0;
            bad_q   <= 1'b0;
            frame_q <= '1;
        end else begin
            unique case (state_q)
                ST_IDLE: low_q <= CNT_W'(1);
                ST_MEASURE: begin
                    if (!sel_s) low_q <= low_q + CNT_W'(1);
                    if (state_d == ST_SAMPLE) begin
                        bit_q <= meas;
                        tmr_q <= (meas >> 1) - CNT_W'(1);
                        idx_q <= '0;
                        bad_q <= 1'b0;
                    end
                end
                ST_SAMPLE: begin
                    if (tick) begin
                        bad_q <= bad_next;
                        idx_q <= idx_q + 5'd1;
                        if (state_d == ST_TURN) tmr_q <= bit_q + (bit_q >> 1) - CNT_W'(1);
                        else                    tmr_q <= bit_q - CNT_W'(1);
                    end else begin
                        tmr_q <= tmr_q - CNT_W'(1);
                    end
                end
                ST_TURN: begin
                    if (tick) begin
                        frame_q <= frame_w;
                        tmr_q   <= bit_q - CNT_W'(1);
                        idx_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q - CNT_W'(1);
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
                        idx_q   <= idx_q + 5'd1;
                        tmr_q   <= bit_q - CNT_W'(1);
                    end else begin
                        tmr_q <= tmr_q - CNT_W'(1);
                    end
                end
                ST_HUNT: low_q <= '0;
                default: low_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        line_oe = (state_q == ST_SEND);
        line_do = line_oe ? frame_q[0] : 1'b1;
    end
endmodule

// File: rtl/keyrep_onewire_chk.sv
module keyrep_onewire_chk
    import keyrep_pkg::*;
#(
    parameter int MIN_BIT = 26,
    parameter int MAX_BIT = 125,
    parameter int NKEYS   = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              line_oe,
    input logic                              line_do,
    input logic                              change_n,
    input logic [NKEYS-1:0]                  keys,
    input kr_state_e                         state_q,
    input logic [$clog2(5*MAX_BIT+8)-1:0]    bit_q
);
    // R1
    sample_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |-> (bit_q >= MIN_BIT && bit_q <= MAX_BIT));

    // R7
    send_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> (bit_q >= MIN_BIT && bit_q <= MAX_BIT));

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !line_do);

    // R4
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> $past(line_do));

    // R8
    change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_oe) && $past(keys, 1) == $past(keys, 2)) |-> change_n);
endmodule

bind keyrep_onewire keyrep_onewire_chk #(
    .MIN_BIT(MIN_BIT),
    .MAX_BIT(MAX_BIT),
    .NKEYS  (NKEYS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_oe (line_oe),
    .line_do (line_do),
    .change_n(change_n),
    .keys    (keys),
    .state_q (state_q),
    .bit_q   (bit_q)
);

// File: tb/sim_keyrep_onewire.sv
module sim_keyrep_onewire;
    localparam int MINB = 8;
    localparam int MAXB = 64;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       host_1w = 1;
    logic       host_rx = 1;
    logic       two_wire = 0;
    logic [9:0] keys = '0;
    logic       line_oe, line_do, change_n;
    logic       line_in;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    assign line_in = line_oe ? line_do : host_1w;

    keyrep_onewire #(.MIN_BIT(MINB), .MAX_BIT(MAXB), .NKEYS(10)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .rx_in(host_rx),
        .two_wire(two_wire), .keys(keys),
        .line_oe(line_oe), .line_do(line_do), .change_n(change_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] ch, input int p, input bit on_rx, input bit stop_v);
        logic [9:0] f;
        f = {stop_v, ch, 1'b0};
        for (int i = 0; i < 10; i++) begin
            if (on_rx) host_rx = f[i]; else host_1w = f[i];
            repeat (p) @(negedge clk);
        end
        host_rx = 1;
        host_1w = 1;
    endtask

    task automatic get_reply(input int p, output bit got, output logic [19:0] fr,
                             output int wait_c, output bit rel, output bit chg_hi);
        got = 0; fr = '0; wait_c = 0; rel = 0; chg_hi = 0;
        while (!line_oe && wait_c < 6 * p) begin
            @(negedge clk);
            wait_c++;
        end
        if (!line_oe) return;
        got    = 1;
        chg_hi = change_n;
        repeat (p / 2) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            fr[i] = line_oe ? line_do : 1'bx;
            if (i < 19) repeat (p) @(negedge clk);
        end
        repeat (p) @(negedge clk);
        rel = !line_oe;
    endtask

    task automatic expect_reply(input string req, input int p, input logic [9:0] k);
        bit got, rel, chg;
        logic [19:0] fr;
        int w;
        logic [7:0] e0, e1;
        e0 = 8'h40 | {2'b00, k[5:0]};
        e1 = 8'h40 | {4'h0, k[9:6]};
        get_reply(p, got, fr, w, rel, chg);
        chk(got, {req, " reply present"}, int'(got), 1);
        if (!got) return;
        chk(fr[0] == 0 && fr[10] == 0, {req, " R3 start bits"}, int'({fr[10], fr[0]}), 0);
        chk(fr[9] == 1 && fr[19] == 1, {req, " R3 stop bits"}, int'({fr[19], fr[9]}), 3);
        chk(fr[8:1] == e0, {req, " R3 byte0"}, int'(fr[8:1]), int'(e0));
        chk(fr[18:11] == e1, {req, " R3 byte1"}, int'(fr[18:11]), int'(e1));
        chk(p + w >= p && p + w <= 3 * p, {req, " R2 turnaround"}, p + w, 2 * p);
        chk(rel, {req, " R4 released"}, int'(rel), 1);
        chk(chg, {req, " R8 change_n high at reply"}, int'(chg), 1);
    endtask

    task automatic expect_silence(input string req, input int p);
        bit got, rel, chg;
        logic [19:0] fr;
        int w;
        get_reply(p, got, fr, w, rel, chg);
        chk(!got, {req, " no reply"}, int'(got), 0);
        repeat (4 * p) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(change_n == 1, "R10 change_n after reset", int'(change_n), 1);
        chk(line_oe == 0, "R10 line_oe after reset", int'(line_oe), 0);
    endtask

    task automatic t_basic();
        send_char(8'h50, 10, 0, 1);
        expect_reply("R1 R2 fast idle keys", 10, keys);
        send_char(8'h50, 50, 0, 1);
        expect_reply("R1 slow idle keys", 50, keys);
    endtask

    task automatic t_keys();
        keys = 10'b00_1000_0101;  // keys 0, 2, 7
        repeat (5) @(negedge clk);
        send_char(8'h50, 20, 0, 1);
        expect_reply("R3 keys 0 2 7", 20, keys);
        keys = 10'h3FF;
        repeat (5) @(negedge clk);
        send_char(8'h50, 12, 0, 1);
        expect_reply("R3 all keys", 12, keys);
    endtask

    task automatic t_bad_char();
        send_char(8'h10, 16, 0, 1);
        expect_silence("R5 char 0x10", 16);
        send_char(8'hD0, 16, 0, 1);
        expect_silence("R5 char 0xD0", 16);
    endtask

    task automatic t_framing();
        send_char(8'h50, 16, 0, 0);
        expect_silence("R6 stop low", 16);
        send_char(8'h50, 16, 0, 1);
        expect_reply("R6 recovery", 16, keys);
    endtask

    task automatic t_range();
        send_char(8'h50, 70, 0, 1);
        expect_silence("R7 too slow", 70);
        send_char(8'h50, 6, 0, 1);
        expect_silence("R7 too fast", 6);
        send_char(8'h50, MAXB, 0, 1);
        expect_reply("R7 max edge", MAXB, keys);
        send_char(8'h50, MINB, 0, 1);
        expect_reply("R7 min edge", MINB, keys);
    endtask

    task automatic t_change();
        keys = 10'h001;
        repeat (3) @(negedge clk);
        chk(change_n == 0, "R8 change_n low after change", int'(change_n), 0);
        repeat (200) @(negedge clk);
        chk(change_n == 0, "R8 change_n held low", int'(change_n), 0);
        send_char(8'h50, 10, 0, 1);
        expect_reply("R8 report", 10, keys);
        chk(change_n == 1, "R8 change_n stays high", int'(change_n), 1);
        keys = 10'h000;
        repeat (3) @(negedge clk);
        chk(change_n == 0, "R8 low on release", int'(change_n), 0);
        send_char(8'h50, 10, 0, 1);
        expect_reply("R8 release report", 10, keys);
    endtask

    task automatic t_two_wire();
        two_wire = 1;
        repeat (4) @(negedge clk);
        send_char(8'h50, 14, 1, 1);
        expect_reply("R9 rx request", 14, keys);
        send_char(8'h50, 14, 0, 1);
        expect_silence("R9 wire ignored in two-wire", 14);
        two_wire = 0;
        repeat (4) @(negedge clk);
        send_char(8'h50, 14, 1, 1);
        expect_silence("R9 rx ignored in one-wire", 14);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic();
        t_keys();
        t_bad_char();
        t_framing();
        t_range();
        t_change();
        t_two_wire();
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule